// File: doc/BRIEF.md
# PHY Power-Up Lock Sequencer

This block takes a serial link PHY from reset to a locked, clock-enabled state without software involvement. A single start pulse releases the PHY reset and points the PHY configuration port at its lock-status location. The block then waits for the PLL to report lock. It issues two configuration writes, one selecting separate-rate clocking and one selecting the 100 MHz PLL reference. It then waits for the PHY to clear its output-enable-pending flag, points the configuration port back at the lock-status location, and waits for the PLL to lock again.

All three waits share one deadline, measured in milliseconds from the accepted start. Each wait samples its flag once per poll interval. If the deadline passes while a wait is still open, the block puts the PHY back into reset and raises an error with a code that names the kind of failure. The millisecond base comes from a prescaler built on the clock frequency parameter, so a bench can run the same logic against a scaled-down deadline. The status flags are assumed to be synchronous to `clk`.

Top module: `phy_lock_seq`

## Requirements
- R1: After reset, `phy_reset` is 1 and `cfg_wr`, `done`, `error` and `err_code` are all 0.
- R2: A start pulse taken while idle, done or failed releases `phy_reset` to 0 and drives `cfg_addr` to 0x10 in the very next cycle. The block then waits for `pll_locked` to be 1. The flag is sampled in the first waiting cycle and then once every POLL_MS milliseconds.
- R3: Once lock is seen, exactly two writes follow in this order: address 0x10 with data 0x8, then address 0x12 with data 0x8.
- R4: Each write takes one setup cycle with address and data driven, then a `cfg_wr` strobe of exactly one cycle with address and data unchanged, then one idle cycle.
- R5: After the writes, the block waits for `out_pending` to be 0. It then drives `cfg_addr` to 0x10, waits for `pll_locked` to be 1, and raises `done` with `phy_reset` held at 0.
- R6: One deadline of TIMEOUT_MS milliseconds, started at the accepted start, bounds all three waits. If it expires while a wait is open, `phy_reset` returns to 1 and `error` rises within one cycle of expiry. `err_code` is then 1 (invalid state) for the lock and relock waits and 2 (timeout) for the output-enable wait. It is 0 when there is no error.
- R7: `done` and `error` are never high together. Each stays high until the next accepted start, which clears both in the following cycle.
- R8: A start pulse that arrives while a sequence is in progress has no effect on the outputs or on the progress of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| pll_locked | input | 1 | PHY PLL lock flag |
| out_pending | input | 1 | PHY output-enable-pending flag (1 while not yet enabled) |
| phy_reset | output | 1 | Reset to the PHY, 1 = held in reset |
| cfg_addr | output | 6 | PHY configuration address / status select |
| cfg_data | output | 4 | PHY configuration write data |
| cfg_wr | output | 1 | One-cycle configuration write strobe |
| done | output | 1 | Sequence finished with the PLL locked (sticky) |
| error | output | 1 | Sequence failed on the deadline (sticky) |
| err_code | output | 2 | 0 none, 1 invalid state, 2 timeout |

## Verification
A wrong state in the sequencer shows up at the ports within a few cycles: a missing, extra or reordered strobe, or a wrong address or data on a strobe, is visible on the same cycle as that strobe. A skipped or stuck wait shows up differently. Either `done` arrives while a PHY flag still says "not ready", or `error` arrives away from the expected deadline cycle, which is exactly TIMEOUT_MS times the cycles per millisecond after start. A start that is wrongly accepted while busy sends the address back to the lock-status location and breaks the remaining writes. The bench therefore sweeps flag arrival delays for all three waits and records every strobe. It also times each failure against the deadline.

// File: rtl/phy_lock_seq_pkg.sv
// Shared types for the PHY power-up lock sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package phy_lock_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_LOCK,
        ST_W1_SET,
        ST_W1_STB,
        ST_W1_GAP,
        ST_W2_SET,
        ST_W2_STB,
        ST_W2_GAP,
        ST_WAIT_OUT,
        ST_WAIT_RELOCK,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_INVALID = 2'd1,
        ERR_TIMEOUT = 2'd2
    } seq_err_t;

    localparam logic [5:0] ADDR_LOCK_STATUS = 6'h10;
    localparam logic [5:0] ADDR_CLK_SCC     = 6'h12;
    localparam logic [3:0] DATA_SEP_RATE    = 4'h8;
    localparam logic [3:0] DATA_PLL_100M    = 4'h8;

endpackage

// File: rtl/seq_ms_prescaler.sv
// Millisecond tick generator.
// Divides clk by CYC_PER_MS; the count restarts on 'clear' so the first
// tick comes CYC_PER_MS cycles after a clear. Assumes CYC_PER_MS >= 2.
module seq_ms_prescaler #(
    parameter int CYC_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic ms_tick
);
    localparam int CW = $clog2(CYC_PER_MS);

    logic [CW-1:0] cnt;

    // Cycle counter that wraps once per millisecond.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (cnt == CW'(CYC_PER_MS - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign ms_tick = (cnt == CW'(CYC_PER_MS - 1));

endmodule

// File: rtl/seq_deadline.sv
// Shared deadline for all waits of the sequence.
// Counts millisecond ticks from 'clear' and saturates at LIMIT_MS, where
// 'expired' stays high until the next clear.
module seq_deadline #(
    parameter int LIMIT_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ms_tick,
    output logic expired
);
    localparam int MW = $clog2(LIMIT_MS + 1);

    logic [MW-1:0] ms_cnt;

    // Elapsed milliseconds since the accepted start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            ms_cnt <= '0;
        else if (ms_tick && !expired)
            ms_cnt <= ms_cnt + 1'b1;
    end

    assign expired = (ms_cnt == MW'(LIMIT_MS));

    AST_DEADLINE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ms_cnt <= MW'(LIMIT_MS)); // R6

endmodule

// File: rtl/seq_poll_timer.sv
// Poll interval timer.
// Produces 'poll' in the first cycle after 'restart' and then once every
// PERIOD cycles, so a wait samples its flag at once and then periodically.
module seq_poll_timer #(
    parameter int PERIOD = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic poll
);
    localparam int PW = $clog2(PERIOD);

    logic [PW-1:0] cnt;

    // Wrapping counter; zero marks a sampling cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (cnt == PW'(PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign poll = (cnt == '0);

endmodule

// File: rtl/phy_lock_seq.sv
// PHY power-up lock sequencer (top).
// Releases PHY reset, waits for PLL lock, writes the clock configuration,
// waits for output enable, waits for relock, all under one deadline.
// Assumes pll_locked and out_pending are synchronous to clk.
module phy_lock_seq
    import phy_lock_seq_pkg::*;
#(
    parameter int CLK_HZ     = 50000000,
    parameter int TIMEOUT_MS = 1000,
    parameter int POLL_MS    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       pll_locked,
    input  logic       out_pending,
    output logic       phy_reset,
    output logic [5:0] cfg_addr,
    output logic [3:0] cfg_data,
    output logic       cfg_wr,
    output logic       done,
    output logic       error,
    output logic [1:0] err_code
);
    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int POLL_CYC   = POLL_MS * CYC_PER_MS;

    seq_state_t state, nxt;
    seq_err_t   code_q, code_nxt;
    logic       busy, accept, ms_tick, expired, poll, poll_restart;

    assign busy   = !(state == ST_IDLE || state == ST_DONE || state == ST_FAIL);
    assign accept = start && !busy;

    seq_ms_prescaler #(.CYC_PER_MS(CYC_PER_MS)) u_ms (
        .clk(clk), .rst_n(rst_n), .clear(accept), .ms_tick(ms_tick));

    seq_deadline #(.LIMIT_MS(TIMEOUT_MS)) u_dl (
        .clk(clk), .rst_n(rst_n), .clear(accept), .ms_tick(ms_tick),
        .expired(expired));

    seq_poll_timer #(.PERIOD(POLL_CYC)) u_poll (
        .clk(clk), .rst_n(rst_n), .restart(poll_restart), .poll(poll));

    // Next-state and failure-code selection.
    always_comb begin
        nxt      = state;
        code_nxt = code_q;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAIL:
                if (start) begin
                    nxt      = ST_WAIT_LOCK;
                    code_nxt = ERR_NONE;
                end
            ST_WAIT_LOCK:
                if (expired) begin
                    nxt      = ST_FAIL;
                    code_nxt = ERR_INVALID;
                end else if (poll && pll_locked) nxt = ST_W1_SET;
            ST_W1_SET: nxt = ST_W1_STB;
            ST_W1_STB: nxt = ST_W1_GAP;
            ST_W1_GAP: nxt = ST_W2_SET;
            ST_W2_SET: nxt = ST_W2_STB;
            ST_W2_STB: nxt = ST_W2_GAP;
            ST_W2_GAP: nxt = ST_WAIT_OUT;
            ST_WAIT_OUT:
                if (expired) begin
                    nxt      = ST_FAIL;
                    code_nxt = ERR_TIMEOUT;
                end else if (poll && !out_pending) nxt = ST_WAIT_RELOCK;
            ST_WAIT_RELOCK:
                if (expired) begin
                    nxt      = ST_FAIL;
                    code_nxt = ERR_INVALID;
                end else if (poll && pll_locked) nxt = ST_DONE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Restart the poll timer whenever a wait state is entered.
    assign poll_restart = (nxt != state) &&
        (nxt == ST_WAIT_LOCK || nxt == ST_WAIT_OUT || nxt == ST_WAIT_RELOCK);

    // State, failure code and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            code_q    <= ERR_NONE;
            phy_reset <= 1'b1;
            cfg_addr  <= '0;
            cfg_data  <= '0;
            cfg_wr    <= 1'b0;
            done      <= 1'b0;
            error     <= 1'b0;
        end else begin
            state     <= nxt;
            code_q    <= code_nxt;
            phy_reset <= (nxt == ST_IDLE || nxt == ST_FAIL);
            cfg_wr    <= (nxt == ST_W1_STB || nxt == ST_W2_STB);
            done      <= (nxt == ST_DONE);
            error     <= (nxt == ST_FAIL);
            if (nxt != state) begin
                unique case (nxt)
                    ST_WAIT_LOCK, ST_WAIT_RELOCK: begin
                        cfg_addr <= ADDR_LOCK_STATUS;
                        cfg_data <= '0;
                    end
                    ST_W1_SET: begin
                        cfg_addr <= ADDR_LOCK_STATUS;
                        cfg_data <= DATA_SEP_RATE;
                    end
                    ST_W2_SET: begin
                        cfg_addr <= ADDR_CLK_SCC;
                        cfg_data <= DATA_PLL_100M;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign err_code = code_q;

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !cfg_wr); // R4
    AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr) |-> ($stable(cfg_addr) && $stable(cfg_data))); // R4
    AST_FAIL_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> phy_reset); // R6
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R7
    AST_DONE_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !phy_reset); // R5
    AST_ERR_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> (err_code != 2'd0)); // R6

endmodule

// File: tb/sim_phy_lock_seq.sv
// Bench for phy_lock_seq: 4 cycles per ms, 100 ms deadline, 5 ms poll.
module sim_phy_lock_seq;
    localparam int CLK_HZ   = 4000;
    localparam int CYC_MS   = 4;
    localparam int TMO_MS   = 100;
    localparam int POLL_MS  = 5;
    localparam int POLL_CYC = POLL_MS * CYC_MS;
    localparam int DL_CYC   = TMO_MS * CYC_MS;
    localparam int NEVER    = 100000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic pll_locked, out_pending;
    logic phy_reset, cfg_wr, done, error;
    logic [5:0] cfg_addr;
    logic [3:0] cfg_data;
    logic [1:0] err_code;

    int checks = 0, failures = 0, cycles = 0;

    // PHY model state
    logic restart = 1'b0;
    int   t = 0, mw = 0, tw = 0;
    int   lock_at = NEVER, out_at = NEVER, relock_at = NEVER;

    // Strobe log
    int   n_wr = 0, t_wr1 = 0;
    logic [5:0] wa [2];
    logic [3:0] wd [2];

    always #10 clk = ~clk;

    phy_lock_seq #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMO_MS), .POLL_MS(POLL_MS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pll_locked(pll_locked),
        .out_pending(out_pending), .phy_reset(phy_reset), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_wr(cfg_wr), .done(done), .error(error),
        .err_code(err_code));

    // PHY model timeline: lock drops at the first write, output clears and
    // lock returns measured from the second write.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (restart) begin
            t <= 0; mw <= 0; tw <= 0;
        end else begin
            t <= t + 1;
            if (cfg_wr) mw <= mw + 1;
            if (cfg_wr && mw == 1) tw <= 0; else tw <= tw + 1;
        end
    end
    assign pll_locked  = (mw == 0) ? (t >= lock_at)
                                   : (mw >= 2 && tw >= out_at + relock_at);
    assign out_pending = !(mw >= 2 && tw >= out_at);

    // Strobe recorder, sampled away from the active edge.
    always @(negedge clk) begin
        if (cfg_wr) begin
            if (n_wr < 2) begin
                wa[n_wr] <= cfg_addr;
                wd[n_wr] <= cfg_data;
            end
            if (n_wr == 0) t_wr1 <= t;
            n_wr <= n_wr + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One sequence; exp_code 0 = success. ign_at > 0 pulses a busy start.
    task automatic run_case(input int la, input int oa, input int ra,
                            input int exp_code, input int ign_at);
        int n;
        lock_at = la; out_at = oa; relock_at = ra;
        @(negedge clk);
        n_wr = 0;
        start = 1'b1; restart = 1'b1;
        @(negedge clk);
        start = 1'b0; restart = 1'b0;
        n = 1;
        check(phy_reset == 1'b0 && cfg_addr == 6'h10, "R2 release+select",
              {phy_reset, cfg_addr}, 16);
        check(done == 1'b0 && error == 1'b0, "R7 cleared by start",
              {done, error}, 0);
        while (!done && !error && n < 2000) begin
            @(negedge clk);
            n++;
            if (n == ign_at) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                n++;
            end
        end
        if (exp_code == 0) begin
            check(done && !error && err_code == 2'd0, ign_at > 0 ? "R8 busy start ignored" : "R5 done",
                  {done, error, err_code}, 8);
            check(n_wr == 2, "R3 write count", n_wr, 2);
            check(pll_locked && !out_pending && !phy_reset, "R5 flags at done",
                  {pll_locked, out_pending, phy_reset}, 4);
            check(t_wr1 >= la + 2 && t_wr1 <= la + POLL_CYC + 3, "R2 poll latency",
                  t_wr1, la + 2);
        end else begin
            check(error && !done && err_code == exp_code[1:0], "R6 error code",
                  {done, error, err_code}, 4 + exp_code);
            check(phy_reset == 1'b1, "R6 reset reasserted", phy_reset, 1);
            check(n >= DL_CYC - 4 && n <= DL_CYC + 8, "R6 deadline", n, DL_CYC + 2);
            check(n_wr == (la == NEVER ? 0 : 2), "R3 writes before failure",
                  n_wr, la == NEVER ? 0 : 2);
        end
        if (n_wr >= 2) begin
            check(wa[0] == 6'h10 && wd[0] == 4'h8, "R3 first write",
                  {wa[0], wd[0]}, 'h108);
            check(wa[1] == 6'h12 && wd[1] == 4'h8, "R3 second write",
                  {wa[1], wd[1]}, 'h128);
        end
        repeat (30) @(negedge clk);
        check(done == (exp_code == 0) && error == (exp_code != 0), "R7 sticky",
              {done, error}, exp_code == 0 ? 2 : 1);
    endtask

    // Strobe shape: setup cycle before, idle cycle after (R4).
    logic [5:0] pa;
    logic [3:0] pd;
    logic       pw;
    always @(negedge clk) begin
        pa <= cfg_addr; pd <= cfg_data; pw <= cfg_wr;
        if (rst_n && cfg_wr) begin
            check(!pw, "R4 strobe width", pw, 0);
            check(pa == cfg_addr && pd == cfg_data, "R4 setup held",
                  {pa, pd}, {cfg_addr, cfg_data});
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(phy_reset && !cfg_wr && !done && !error && err_code == 0,
              "R1 reset state", {phy_reset, cfg_wr, done, error, err_code}, 32);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(phy_reset && !done && !error, "R1 idle hold", {phy_reset, done, error}, 4);
        // Near-exhaustive sweep of flag arrival delays (cycles)
        foreach (wa[i]) begin end
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int c = 0; c < 3; c++)
                    run_case(a * 23, b * 17, c * 29, 0, 0);
        run_case(NEVER, 0, 0, 1, 0);
        run_case(7, NEVER, 0, 2, 0);
        run_case(7, 13, NEVER, 1, 0);
        run_case(7, 13, 21, 0, 30);
        run_case(0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule